// File: doc/BRIEF.md
# Floating-point status/control register

This block holds the 32-bit status and control word of a single-precision floating-point coprocessor. Bit positions are numbered 32 to 63 in big-endian style, so `rd_data[i]` carries position `63-i`, and position 32 is the most significant bit. The arithmetic units post result updates to it. Each update carries sticky exception causes, and it carries a five-bit result class unless it comes from a compare. Software changes the word through four write forms: setting one bit, clearing one bit, writing whole nibble fields from a data word under a field mask, and writing a four-bit immediate into one chosen field. The current value can be read at any time.

Every software write is slow on purpose. Once accepted, it lands a fixed number of cycles later, and `busy` stays high until then. Requests made while `busy` is high are not taken, so a requester keeps `cmd_valid` asserted until its request is taken. The block derives three summary bits itself: the any-exception latch, the invalid-operation OR, and the enabled-exception OR. Some architected positions are tied to zero. The non-IEEE bit and the rounding-control bits are stored but drive nothing. The only exception mode is that exceptions are ignored, so no trap is ever raised.

Top module: `fp_status_reg`

## Requirements
- R1: After reset, and after a reset that cuts off a pending write, `rd_data` is 0 and `busy` is 0. The cut-off write never lands.
- R2: Positions 38, 39, 44, 45 and 46 always read 0, whatever is written or posted.
- R3: A request is accepted on a rising edge where `cmd_valid` is 1 and `busy` is 0. `busy` is 1 for the next WR_CYCLES cycles (36 by default). The write appears on `rd_data` at the edge WR_CYCLES edges after acceptance, and `busy` falls at that same edge. `rd_data` shows the register itself with no delay.
- R4: A request made while `busy` is 1 is not taken. If `cmd_valid` is held, the request is taken on the first edge after `busy` falls.
- R5: `cmd_op`=0 sets, and `cmd_op`=1 clears, the single position 32+`cmd_bit`.
- R6: When `cmd_op`=2, each field f (positions 32+4f to 35+4f) whose `cmd_fmask[f]` is 1 takes the matching bits of `cmd_data`. Fields whose mask bit is 0 keep their value.
- R7: When `cmd_op`=3, field `cmd_fld` takes `cmd_imm`, with `cmd_imm[3]` at the lowest-numbered position of that field.
- R8: When `ar_valid` is 1, the register changes at the next edge. `ar_cause` (same layout as `rd_data`) is ORed into positions 35-37, 40-43 and 53-55, and its other bits are dropped. If `ar_cmp` is 0, `ar_cls[4:0]` replaces positions 47-51, with `ar_cls[4]` at 47. If `ar_cmp` is 1, positions 47-51 are left unchanged.
- R9: Position 32 becomes 1 whenever any of positions 35-37, 40-43 or 53-55 goes from 0 to 1. At all other times it keeps the value last written by software.
- R10: Position 34 is the OR of positions 40-43 and 53-55. Position 33 is the OR of (35 and 57), (36 and 58), (37 and 59) and (34 and 56). Software writes to positions 33 and 34 have no direct effect.
- R11: Positions 61-63 are stored and read back, and changing them affects no other bit.
- R12: If a software write lands in the same cycle as an arithmetic update, the software result is applied first. The update is then merged on top, and the summary bits are computed from the combined value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Software write request |
| cmd_op | input | 2 | Write form: 0 set bit, 1 clear bit, 2 masked fields, 3 field immediate |
| cmd_bit | input | 5 | Bit offset from position 32 for set/clear |
| cmd_fmask | input | 8 | Field mask for the masked write, bit f selects field f |
| cmd_data | input | 32 | Data word for the masked write |
| cmd_fld | input | 3 | Field number for the immediate write |
| cmd_imm | input | 4 | Immediate nibble |
| busy | output | 1 | A write is pending; requests are not taken |
| ar_valid | input | 1 | Arithmetic result update |
| ar_cause | input | 32 | Exception causes in register layout |
| ar_cls | input | 5 | Result class, bit 4 at position 47 |
| ar_cmp | input | 1 | Update comes from a compare |
| rd_data | output | 32 | Current register value |

## Verification
The two paths that can collide are the landing of a slow software write and an arithmetic update. The bench provokes this by accepting a field write that clears the any-exception latch and the overflow bit. It then counts cycles and posts an underflow cause with a new class on exactly the edge where the write lands. The expected word is worked out by hand: the software field value comes first, the update is ORed and inserted on top, and the any-exception bit is then raised again by the new underflow. Sampling one cycle earlier shows the old word, which confirms that neither source leaked in early.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

   localparam int REG_W    = 32;
   localparam int FLD_W    = 4;
   localparam int NUM_FLD  = REG_W / FLD_W;
   localparam int BSEL_W   = $clog2(REG_W);
   localparam int FSEL_W   = $clog2(NUM_FLD);
   localparam int POS_BASE = 32;

   // architected positions (big-endian numbering)
   localparam int P_SUM_ANY  = 32;
   localparam int P_SUM_EN   = 33;
   localparam int P_SUM_INV  = 34;
   localparam int P_OVF      = 35;
   localparam int P_UNF      = 36;
   localparam int P_DZ       = 37;
   localparam int P_INX      = 38;
   localparam int P_SNAN     = 39;
   localparam int P_INF_SUB  = 40;
   localparam int P_INF_DIV  = 41;
   localparam int P_ZERO_DIV = 42;
   localparam int P_INF_MUL  = 43;
   localparam int P_CMP_INV  = 44;
   localparam int P_FRND     = 45;
   localparam int P_FINX     = 46;
   localparam int P_CLS_TOP  = 47;
   localparam int P_CLS_END  = 51;
   localparam int P_SOFT     = 53;
   localparam int P_SQRT     = 54;
   localparam int P_CVI      = 55;
   localparam int P_EN_INV   = 56;
   localparam int P_EN_OVF   = 57;
   localparam int P_EN_UNF   = 58;
   localparam int P_EN_DZ    = 59;
   localparam int P_EN_INX   = 60;
   localparam int P_NONIEEE  = 61;

   localparam int CLS_W = P_CLS_END - P_CLS_TOP + 1;

   typedef enum logic [1:0] {
      OP_SET_BIT  = 2'd0,
      OP_CLR_BIT  = 2'd1,
      OP_FLD_MASK = 2'd2,
      OP_FLD_IMM  = 2'd3
   } fpsr_op_e;

   typedef struct packed {
      fpsr_op_e            op;
      logic [BSEL_W-1:0]   bitsel;
      logic [NUM_FLD-1:0]  fmask;
      logic [REG_W-1:0]    data;
      logic [FSEL_W-1:0]   fld;
      logic [FLD_W-1:0]    imm;
   } fpsr_cmd_t;

   function automatic int pidx(input int pos);
      return POS_BASE + REG_W - 1 - pos;
   endfunction

   function automatic logic [REG_W-1:0] pbit(input int pos);
      logic [REG_W-1:0] v;
      v = '0;
      v[pidx(pos)] = 1'b1;
      return v;
   endfunction

   localparam int IX_SUM_ANY = pidx(P_SUM_ANY);
   localparam int IX_SUM_EN  = pidx(P_SUM_EN);
   localparam int IX_SUM_INV = pidx(P_SUM_INV);
   localparam int IX_OVF     = pidx(P_OVF);
   localparam int IX_UNF     = pidx(P_UNF);
   localparam int IX_DZ      = pidx(P_DZ);
   localparam int IX_INX     = pidx(P_INX);
   localparam int IX_EN_INV  = pidx(P_EN_INV);
   localparam int IX_EN_OVF  = pidx(P_EN_OVF);
   localparam int IX_EN_UNF  = pidx(P_EN_UNF);
   localparam int IX_EN_DZ   = pidx(P_EN_DZ);
   localparam int IX_EN_INX  = pidx(P_EN_INX);
   localparam int IX_CLS_HI  = pidx(P_CLS_TOP);
   localparam int IX_CLS_LO  = pidx(P_CLS_END);

   // positions tied to zero
   localparam logic [REG_W-1:0] M_ZERO = pbit(P_INX) | pbit(P_SNAN) | pbit(P_CMP_INV)
                                       | pbit(P_FRND) | pbit(P_FINX);
   // invalid-operation causes
   localparam logic [REG_W-1:0] M_INV = pbit(P_INF_SUB) | pbit(P_INF_DIV) | pbit(P_ZERO_DIV)
                                      | pbit(P_INF_MUL) | pbit(P_SOFT) | pbit(P_SQRT)
                                      | pbit(P_CVI);
   // every sticky cause that may raise the any-exception latch
   localparam logic [REG_W-1:0] M_EXC = M_INV | pbit(P_OVF) | pbit(P_UNF) | pbit(P_DZ);

endpackage

// File: rtl/fpsr_wrseq.sv
module fpsr_wrseq
   import fpsr_pkg::*;
#(
   parameter int WR_CYCLES = 36
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  fpsr_cmd_t req_cmd,
   output logic      busy,
   output logic      commit,
   output fpsr_cmd_t cur_cmd
);

   localparam int CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;

   if (WR_CYCLES < 2) begin : g_bad_len
      $error("fpsr_wrseq: WR_CYCLES must be at least 2");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   fpsr_cmd_t        cmd_q;
   logic             accept;

   assign accept = req_valid && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         cmd_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(WR_CYCLES - 1);
         cmd_q  <= req_cmd;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign commit  = busy_q && (cnt_q == '0);
   assign cur_cmd = cmd_q;

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(cmd_q)); // R4
   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> busy_q); // R3
   AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy_q); // R3

endmodule

// File: rtl/fpsr_swmerge.sv
module fpsr_swmerge
   import fpsr_pkg::*;
(
   input  logic [REG_W-1:0] cur,
   input  fpsr_cmd_t        cmd,
   output logic [REG_W-1:0] sw_val
);

   logic [REG_W-1:0] one_hot;
   logic [REG_W-1:0] mask_sel;
   logic [REG_W-1:0] imm_sel;
   logic [REG_W-1:0] imm_rep;

   assign one_hot = {1'b1, {(REG_W-1){1'b0}}} >> cmd.bitsel;
   assign imm_rep = {NUM_FLD{cmd.imm}};

   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      localparam int HI = REG_W - 1 - f * FLD_W;
      assign mask_sel[HI -: FLD_W] = {FLD_W{cmd.fmask[f]}};
      assign imm_sel[HI -: FLD_W]  = {FLD_W{cmd.fld == FSEL_W'(f)}};
   end

   always_comb begin
      sw_val = cur;
      case (cmd.op)
         OP_SET_BIT:  sw_val = cur | one_hot;
         OP_CLR_BIT:  sw_val = cur & ~one_hot;
         OP_FLD_MASK: sw_val = (cur & ~mask_sel) | (cmd.data & mask_sel);
         OP_FLD_IMM:  sw_val = (cur & ~imm_sel) | (imm_rep & imm_sel);
         default:     sw_val = cur;
      endcase
   end

endmodule

// File: rtl/fpsr_hwmerge.sv
module fpsr_hwmerge
   import fpsr_pkg::*;
(
   input  logic [REG_W-1:0] base,
   input  logic             upd_valid,
   input  logic [REG_W-1:0] upd_cause,
   input  logic [CLS_W-1:0] upd_cls,
   input  logic             upd_cmp,
   output logic [REG_W-1:0] merged
);

   always_comb begin
      merged = base;
      if (upd_valid) begin
         merged = merged | (upd_cause & M_EXC);
         if (!upd_cmp) begin
            merged[IX_CLS_HI:IX_CLS_LO] = upd_cls;
         end
      end
   end

endmodule

// File: rtl/fpsr_summary.sv
module fpsr_summary
   import fpsr_pkg::*;
#(
   parameter bit KEEP_NONIEEE = 1'b1
) (
   input  logic [REG_W-1:0] prev,
   input  logic [REG_W-1:0] raw,
   output logic [REG_W-1:0] nxt
);

   logic [REG_W-1:0] zero_m;
   logic [REG_W-1:0] clean;
   logic             new_exc;
   logic             inv_any;
   logic             en_any;

   if (KEEP_NONIEEE) begin : g_ni_store
      assign zero_m = M_ZERO;
   end else begin : g_ni_tie
      assign zero_m = M_ZERO | pbit(P_NONIEEE);
   end

   assign clean   = raw & ~zero_m;
   assign new_exc = |(clean & M_EXC & ~prev);
   assign inv_any = |(clean & M_INV);
   assign en_any  = (clean[IX_OVF] & clean[IX_EN_OVF])
                  | (clean[IX_UNF] & clean[IX_EN_UNF])
                  | (clean[IX_DZ]  & clean[IX_EN_DZ])
                  | (clean[IX_INX] & clean[IX_EN_INX])
                  | (inv_any       & clean[IX_EN_INV]);

   always_comb begin
      nxt             = clean;
      nxt[IX_SUM_ANY] = clean[IX_SUM_ANY] | new_exc;
      nxt[IX_SUM_INV] = inv_any;
      nxt[IX_SUM_EN]  = en_any;
   end

endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
   import fpsr_pkg::*;
#(
   parameter int WR_CYCLES    = 36,
   parameter bit KEEP_NONIEEE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [1:0]  cmd_op,
   input  logic [4:0]  cmd_bit,
   input  logic [7:0]  cmd_fmask,
   input  logic [31:0] cmd_data,
   input  logic [2:0]  cmd_fld,
   input  logic [3:0]  cmd_imm,
   output logic        busy,
   input  logic        ar_valid,
   input  logic [31:0] ar_cause,
   input  logic [4:0]  ar_cls,
   input  logic        ar_cmp,
   output logic [31:0] rd_data
);

   if (REG_W != 32 || NUM_FLD != 8 || CLS_W != 5) begin : g_bad_shape
      $error("fp_status_reg: port widths do not match the package layout");
   end

   fpsr_cmd_t        cmd_in;
   fpsr_cmd_t        cmd_cur;
   logic             commit;
   logic [REG_W-1:0] reg_q;
   logic [REG_W-1:0] sw_val;
   logic [REG_W-1:0] base;
   logic [REG_W-1:0] merged;
   logic [REG_W-1:0] nxt;

   always_comb begin
      cmd_in.op     = fpsr_op_e'(cmd_op);
      cmd_in.bitsel = cmd_bit;
      cmd_in.fmask  = cmd_fmask;
      cmd_in.data   = cmd_data;
      cmd_in.fld    = cmd_fld;
      cmd_in.imm    = cmd_imm;
   end

   fpsr_wrseq #(.WR_CYCLES(WR_CYCLES)) u_wrseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (cmd_valid),
      .req_cmd   (cmd_in),
      .busy      (busy),
      .commit    (commit),
      .cur_cmd   (cmd_cur)
   );

   fpsr_swmerge u_swmerge (
      .cur    (reg_q),
      .cmd    (cmd_cur),
      .sw_val (sw_val)
   );

   assign base = commit ? sw_val : reg_q;

   fpsr_hwmerge u_hwmerge (
      .base      (base),
      .upd_valid (ar_valid),
      .upd_cause (ar_cause),
      .upd_cls   (ar_cls),
      .upd_cmp   (ar_cmp),
      .merged    (merged)
   );

   fpsr_summary #(.KEEP_NONIEEE(KEEP_NONIEEE)) u_summary (
      .prev (reg_q),
      .raw  (merged),
      .nxt  (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else begin
         reg_q <= nxt;
      end
   end

   assign rd_data = reg_q;

   AST_HARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_q & M_ZERO) == '0); // R2
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !ar_valid) |=> $stable(reg_q)); // R3
   AST_INV_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      reg_q[IX_SUM_INV] == |(reg_q & M_INV)); // R10
   AST_ANY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(reg_q & M_EXC & ~$past(reg_q))) |-> reg_q[IX_SUM_ANY]); // R9
   AST_CMP_KEEPS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_valid && ar_cmp && !commit) |=> $stable(reg_q[IX_CLS_HI:IX_CLS_LO])); // R8

endmodule

// File: tb/test_fp_status_reg.sv
module test_fp_status_reg;

   localparam int WR = 36;

   typedef struct packed {
      logic [1:0]  op;
      logic [4:0]  bsel;
      logic [7:0]  fm;
      logic [31:0] data;
      logic [2:0]  fld;
      logic [3:0]  imm;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   // sequential vectors; each expected value follows from the previous one
   localparam vec_t VECS [14] = '{
      '{2'd0, 5'd3,  8'h00, 32'h0,        3'd0, 4'h0, 32'h90000000, 4'd5 },  // R5 R9 set overflow
      '{2'd0, 5'd25, 8'h00, 32'h0,        3'd0, 4'h0, 32'hD0000040, 4'd10},  // R10 enable overflow
      '{2'd1, 5'd0,  8'h00, 32'h0,        3'd0, 4'h0, 32'h50000040, 4'd5 },  // R5 clear latch
      '{2'd3, 5'd0,  8'h00, 32'h0,        3'd2, 4'hA, 32'hF0A00040, 4'd7 },  // R7 invalid causes
      '{2'd2, 5'd0,  8'h41, 32'h00000080, 3'd0, 4'h0, 32'h60A00080, 4'd6 },  // R6 fields 0 and 6
      '{2'd3, 5'd0,  8'h00, 32'h0,        3'd1, 4'hF, 32'hECA00080, 4'd2 },  // R2 38/39 stay 0
      '{2'd3, 5'd0,  8'h00, 32'h0,        3'd3, 4'hF, 32'hECA10080, 4'd2 },  // R2 44-46 stay 0
      '{2'd3, 5'd0,  8'h00, 32'h0,        3'd7, 4'h7, 32'hECA10087, 4'd11},  // R11 mode bits
      '{2'd2, 5'd0,  8'hFF, 32'hFFFFFFFF, 3'd0, 4'h0, 32'hFCF1FFFF, 4'd6 },  // R6 all fields
      '{2'd2, 5'd0,  8'hFF, 32'h00000000, 3'd0, 4'h0, 32'h00000000, 4'd6 },  // R6 clear all
      '{2'd0, 5'd6,  8'h00, 32'h0,        3'd0, 4'h0, 32'h00000000, 4'd2 },  // R2 tied bit
      '{2'd0, 5'd2,  8'h00, 32'h0,        3'd0, 4'h0, 32'h00000000, 4'd10},  // R10 derived
      '{2'd0, 5'd1,  8'h00, 32'h0,        3'd0, 4'h0, 32'h00000000, 4'd10},  // R10 derived
      '{2'd0, 5'd0,  8'h00, 32'h0,        3'd0, 4'h0, 32'h80000000, 4'd9 }   // R9 software set
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic [1:0]  cmd_op;
   logic [4:0]  cmd_bit;
   logic [7:0]  cmd_fmask;
   logic [31:0] cmd_data;
   logic [2:0]  cmd_fld;
   logic [3:0]  cmd_imm;
   logic        busy;
   logic        ar_valid;
   logic [31:0] ar_cause;
   logic [4:0]  ar_cls;
   logic        ar_cmp;
   logic [31:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fp_status_reg #(.WR_CYCLES(WR)) i_fp_status_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_bit   (cmd_bit),
      .cmd_fmask (cmd_fmask),
      .cmd_data  (cmd_data),
      .cmd_fld   (cmd_fld),
      .cmd_imm   (cmd_imm),
      .busy      (busy),
      .ar_valid  (ar_valid),
      .ar_cause  (ar_cause),
      .ar_cls    (ar_cls),
      .ar_cmp    (ar_cmp),
      .rd_data   (rd_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive_cmd(input logic [1:0] op, input logic [4:0] b, input logic [7:0] fm,
                            input logic [31:0] d, input logic [2:0] f, input logic [3:0] im);
      cmd_op = op; cmd_bit = b; cmd_fmask = fm; cmd_data = d; cmd_fld = f; cmd_imm = im;
   endtask

   task automatic post_upd(input logic [31:0] cause, input logic [4:0] cls, input logic cmp);
      ar_valid = 1'b1; ar_cause = cause; ar_cls = cls; ar_cmp = cmp;
   endtask

   // called at a negedge; returns at a negedge with the write landed
   task automatic run_vec(input vec_t v);
      logic [31:0] old;
      string       tag;
      tag = $sformatf("R%0d", v.req);
      old = rd_data;
      drive_cmd(v.op, v.bsel, v.fm, v.data, v.fld, v.imm);
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R3 busy after accept", {31'd0, busy}, 32'd1);
      repeat (WR - 1) @(posedge clk);
      @(negedge clk);
      chk("R3 value before landing", rd_data, old);
      chk("R3 busy before landing", {31'd0, busy}, 32'd1);
      @(posedge clk);
      @(negedge clk);
      chk("R3 busy after landing", {31'd0, busy}, 32'd0);
      chk(tag, rd_data, v.exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      drive_cmd(2'd0, 5'd0, 8'd0, 32'd0, 3'd0, 4'd0);
      ar_valid = 1'b0; ar_cause = '0; ar_cls = '0; ar_cmp = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset value", rd_data, 32'h0);
      chk("R1 reset busy", {31'd0, busy}, 32'd0);
      @(negedge clk);

      foreach (VECS[i]) run_vec(VECS[i]);

      // R4: request held across busy, changed to a second command meanwhile
      drive_cmd(2'd0, 5'd24, 8'd0, 32'd0, 3'd0, 4'd0);
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      drive_cmd(2'd0, 5'd25, 8'd0, 32'd0, 3'd0, 4'd0);
      repeat (WR - 1) @(posedge clk);
      @(negedge clk);
      chk("R4 nothing landed early", rd_data, 32'h80000000);
      @(posedge clk);
      @(negedge clk);
      chk("R4 first write only", rd_data, 32'h80000080);
      chk("R4 busy low between", {31'd0, busy}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R4 held request taken", {31'd0, busy}, 32'd1);
      repeat (WR - 1) @(posedge clk);
      @(negedge clk);
      chk("R4 second pending", rd_data, 32'h80000080);
      @(posedge clk);
      @(negedge clk);
      chk("R4 second landed", rd_data, 32'h800000C0);

      // R8 arithmetic updates: cause with tied bit 38, then compare, then class
      post_upd(32'h12000000, 5'b01000, 1'b0);
      @(posedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      chk("R8 cause and class", rd_data, 32'hD00080C0);
      post_upd(32'h04000000, 5'b11111, 1'b1);
      @(posedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      chk("R8 compare keeps class", rd_data, 32'hD40080C0);
      post_upd(32'h00000000, 5'b10011, 1'b0);
      @(posedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      chk("R8 class replaced", rd_data, 32'hD40130C0);

      // R12 software landing and arithmetic update in the same cycle
      drive_cmd(2'd2, 5'd0, 8'h01, 32'h00000000, 3'd0, 4'd0);
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (WR - 1) @(posedge clk);
      @(negedge clk);
      chk("R12 before collision", rd_data, 32'hD40130C0);
      post_upd(32'h08000000, 5'b00100, 1'b0);
      @(posedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      chk("R12 merged result", rd_data, 32'h8C0040C0);
      chk("R12 busy low", {31'd0, busy}, 32'd0);

      // R1 reset cuts off a pending write
      drive_cmd(2'd1, 5'd0, 8'd0, 32'd0, 3'd0, 4'd0);
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset mid-write value", rd_data, 32'h0);
      chk("R1 reset mid-write busy", {31'd0, busy}, 32'd0);
      repeat (WR + 2) @(posedge clk);
      @(negedge clk);
      chk("R1 cut-off write absent", rd_data, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule